// File: doc/BRIEF.md
# Masked burst write receiver

This block takes write operations from a 16-bit inbound channel and lands them in a small pool of write-buffer entries. Each entry holds 64 bytes, split into a lower and an upper 32-byte half, and a 32-bit byte-pair enable mask. An operation opens with a header word that is qualified by a one-cycle strobe. Data then arrives on every following cycle with no further qualifier.

The header decides three things: whether each 32-byte part begins with a mask word, whether the transfer covers both halves or only one, and, for a single-half transfer, which half it targets. Data beats carry two bytes each and fill the chosen half in ascending byte order. While an operation is running, the slot output names the entry being written. Once the operation completes, the slot output shows the lowest free entry, or a full code when every entry is taken. Entries are handed back through a release port. A read port lets the holder of the buffer inspect any entry.

Top module: `mbw_receiver`

## Requirements
- R1: After reset, every entry is free, each entry's stored bytes and mask read as zero, `wr_slot` reads 0, and `busy`, `op_done` and `hdr_err` are low.
- R2: A header is a `rx_word` value sampled while `hdr_vld` is high. Bit 0 means a mask word is present, bit 1 selects a 64-byte transfer, and bit 2 selects the upper half for a 32-byte transfer. Bits 15:3 have no effect.
- R3: Beats arrive on consecutive cycles, starting the cycle after the header. Each 32-byte part consists of 16 data beats. In data beat k of a part, bits 7:0 are stored as byte 2k of that half and bits 15:8 as byte 2k+1. Byte b of an entry is `rd_data[8b+7:8b]`, and the upper half is bytes 32 to 63.
- R4: When the mask flag is set, the first beat of each part is a mask word. It is stored raw in `rd_mask[15:0]` for the lower half or `rd_mask[31:16]` for the upper half, and bit k enables byte pair k. When the flag is clear, there is no mask beat and that half's mask is set to all ones.
- R5: A 32-byte transfer writes only the half selected by bit 2. The other half of the entry keeps its previous bytes and mask.
- R6: A 64-byte transfer writes the lower half, then the upper half, with a mask beat before each half when masks are present. Bit 2 is then ignored. `busy` stays high from the cycle after the header through the last beat, which is 32 beats, or 34 beats with masks.
- R7: While `busy` is high, `wr_slot` shows the entry being written. In the cycle after the last beat, `op_done` is high for exactly one cycle, `busy` is low, and `wr_slot` shows the lowest free entry, or 8 when none is free.
- R8: A header strobe that arrives while `busy` is high starts nothing and does not disturb the running transfer. `hdr_err` is then high for exactly the next cycle.
- R9: A header strobe while `wr_slot` reads 8 is not accepted. `busy` stays low, `hdr_err` stays low, and the stored entries are unchanged.
- R10: `rel_vld` with `rel_idx` frees that entry from the next cycle on. When idle, `wr_slot` then shows the lowest free index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | Header strobe |
| rx_word | input | 16 | Header, mask or data word |
| rel_vld | input | 1 | Release request |
| rel_idx | input | 2 | Entry to release |
| rd_idx | input | 2 | Entry selected on the read port |
| wr_slot | output | 4 | Entry being written, lowest free entry, or 8 when full |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle pulse after an operation completes |
| hdr_err | output | 1 | One-cycle pulse after a header arrives while busy |
| rd_data | output | 512 | Bytes of the selected entry |
| rd_mask | output | 32 | Byte-pair enables of the selected entry, upper half in the top 16 bits |

## Verification
The assertions assume that beats follow the header with no gaps, because the channel has no per-beat qualifier. They also assume that a release names an entry other than the one currently being filled. The stimulus therefore drives every beat on the cycle after the previous one and issues releases only between operations. The one exception is a deliberate header strobe in the middle of a transfer. There, the same word is still meant as data, and its stored bytes are compared like any other beat.

// File: rtl/mbw_pkg.sv
`timescale 1ns/1ps
package mbw_pkg;
  // header field positions: the sequencer decodes these
  localparam int HDR_MASK_BIT  = 0;
  localparam int HDR_WIDE_BIT  = 1;
  localparam int HDR_UPPER_BIT = 2;
  localparam int WORD_W        = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MASK = 2'd1,
    ST_DATA = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mbw_seq.sv
`timescale 1ns/1ps
module mbw_seq
  import mbw_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int BEATS   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_vld,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              full,
  input  logic [IDX_W-1:0]  cur_slot,
  output logic              busy,
  output logic              hdr_err,
  output logic              op_done,
  output logic              op_fin,
  output logic              wr_data_en,
  output logic              wr_mask_en,
  output logic              wr_fill,
  output logic              wr_half,
  output logic [BEAT_W-1:0] wr_beat,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_word
);
  seq_st_e           st_q;
  logic              part_q, masked_q, wide_q, upper_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  idx_q;
  logic              start, last_beat, more_part;

  function automatic seq_st_e part_entry(input logic masked);
    return masked ? ST_MASK : ST_DATA;
  endfunction

  assign busy       = (st_q != ST_IDLE);
  assign start      = hdr_vld && !busy && !full;
  assign last_beat  = (st_q == ST_DATA) && (beat_q == BEAT_W'(BEATS - 1));
  assign more_part  = wide_q && !part_q;
  assign op_fin     = last_beat && !more_part;

  assign wr_data_en = (st_q == ST_DATA);
  assign wr_mask_en = (st_q == ST_MASK);
  assign wr_fill    = wr_data_en && (beat_q == '0) && !masked_q;
  assign wr_half    = wide_q ? part_q : upper_q;
  assign wr_beat    = beat_q;
  assign wr_idx     = idx_q;
  assign wr_word    = rx_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      part_q   <= 1'b0;
      masked_q <= 1'b0;
      wide_q   <= 1'b0;
      upper_q  <= 1'b0;
      beat_q   <= '0;
      idx_q    <= '0;
      hdr_err  <= 1'b0;
      op_done  <= 1'b0;
    end else begin
      hdr_err <= hdr_vld && busy;
      op_done <= op_fin;
      case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= part_entry(rx_word[HDR_MASK_BIT]);
          masked_q <= rx_word[HDR_MASK_BIT];
          wide_q   <= rx_word[HDR_WIDE_BIT];
          upper_q  <= rx_word[HDR_UPPER_BIT];
          part_q   <= 1'b0;
          beat_q   <= '0;
          idx_q    <= cur_slot;
        end
        ST_MASK: st_q <= ST_DATA;
        ST_DATA: begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            beat_q <= '0;
            if (more_part) begin
              part_q <= 1'b1;
              st_q   <= part_entry(masked_q);
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  busy_hdr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && busy |=> hdr_err);
  // R4
  mask_beat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && rx_word[HDR_MASK_BIT] |=> wr_mask_en);
  // R3
  data_follows_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !rx_word[HDR_MASK_BIT] |=> wr_data_en && (wr_beat == '0));
  // R6
  second_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && more_part |=> wr_half && (wr_mask_en || wr_data_en));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
endmodule

// File: rtl/mbw_pool.sv
`timescale 1ns/1ps
module mbw_pool #(
  parameter int ENTRIES     = 4,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int SLOT_W     = $clog2(ENTRIES) + 2,
  localparam int FULL_CODE  = 2 * ENTRIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              rel_vld,
  input  logic [IDX_W-1:0]  rel_idx,
  output logic [SLOT_W-1:0] free_code,
  output logic [IDX_W-1:0]  free_idx,
  output logic              full
);
  logic [ENTRIES-1:0] occ_q, occ_d;

  // lowest index whose occupied bit is clear, or the full code
  function automatic logic [SLOT_W-1:0] lowest_free(input logic [ENTRIES-1:0] o);
    logic [SLOT_W-1:0] c;
    c = SLOT_W'(FULL_CODE);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!o[i]) c = SLOT_W'(i);
    return c;
  endfunction

  always_comb begin
    occ_d = occ_q;
    if (rel_vld)   occ_d[rel_idx]   = 1'b0;
    if (alloc_vld) occ_d[alloc_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign free_code = lowest_free(occ_q);
  assign free_idx  = free_code[IDX_W-1:0];
  assign full      = &occ_q;

  // R7
  alloc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |=> occ_q[$past(alloc_idx)]);
  // R7
  alloc_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> !occ_q[alloc_idx]);
  // R10
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld && !(alloc_vld && (alloc_idx == rel_idx)) |=> !occ_q[$past(rel_idx)]);
  // R9
  full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (free_code == SLOT_W'(FULL_CODE)));
  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_code < SLOT_W'(ENTRIES)) || (free_code == SLOT_W'(FULL_CODE)));
endmodule

// File: rtl/mbw_store.sv
`timescale 1ns/1ps
module mbw_store
  import mbw_pkg::*;
#(
  parameter int ENTRIES       = 4,
  parameter int BEATS         = 16,
  localparam int IDX_W        = $clog2(ENTRIES),
  localparam int BEAT_W       = $clog2(BEATS),
  localparam int HALF_BYTES   = 2 * BEATS,
  localparam int ENTRY_BITS   = 2 * HALF_BYTES * 8,
  localparam int MASK_BITS    = 2 * BEATS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_data_en,
  input  logic                  wr_mask_en,
  input  logic                  wr_fill,
  input  logic                  wr_half,
  input  logic [BEAT_W-1:0]     wr_beat,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WORD_W-1:0]     wr_word,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [ENTRY_BITS-1:0] rd_data,
  output logic [MASK_BITS-1:0]  rd_mask
);
  logic [ENTRY_BITS-1:0] all_data [ENTRIES];
  logic [MASK_BITS-1:0]  all_mask [ENTRIES];

  // bit position of the two bytes carried by one data beat
  function automatic int byte_lsb(input logic half, input logic [BEAT_W-1:0] beat);
    return ((half ? HALF_BYTES : 0) + 2 * int'(beat)) * 8;
  endfunction

  function automatic int mask_lsb(input logic half);
    return half ? BEATS : 0;
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [ENTRY_BITS-1:0] dq;
    logic [MASK_BITS-1:0]  mq;
    logic                  hit;
    assign hit = (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dq <= '0;
        mq <= '0;
      end else if (hit) begin
        if (wr_data_en) dq[byte_lsb(wr_half, wr_beat) +: 16] <= wr_word;
        if (wr_mask_en) mq[mask_lsb(wr_half) +: BEATS] <= wr_word[BEATS-1:0];
        else if (wr_fill) mq[mask_lsb(wr_half) +: BEATS] <= '1;
      end
    end

    assign all_data[e] = dq;
    assign all_mask[e] = mq;
  end

  assign rd_data = all_data[rd_idx];
  assign rd_mask = all_mask[rd_idx];

  // R4
  mask_vs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mask_en && (wr_data_en || wr_fill)));
endmodule

// File: rtl/mbw_receiver.sv
`timescale 1ns/1ps
module mbw_receiver
  import mbw_pkg::*;
#(
  parameter int ENTRIES       = 4,
  parameter int BEATS         = 16,
  localparam int IDX_W        = $clog2(ENTRIES),
  localparam int SLOT_W       = $clog2(ENTRIES) + 2,
  localparam int BEAT_W       = $clog2(BEATS),
  localparam int ENTRY_BITS   = 2 * 2 * BEATS * 8,
  localparam int MASK_BITS    = 2 * BEATS,
  localparam int FULL_CODE    = 2 * ENTRIES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hdr_vld,
  input  logic [WORD_W-1:0]     rx_word,
  input  logic                  rel_vld,
  input  logic [IDX_W-1:0]      rel_idx,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [SLOT_W-1:0]     wr_slot,
  output logic                  busy,
  output logic                  op_done,
  output logic                  hdr_err,
  output logic [ENTRY_BITS-1:0] rd_data,
  output logic [MASK_BITS-1:0]  rd_mask
);
  logic              full, op_fin;
  logic [SLOT_W-1:0] free_code;
  logic [IDX_W-1:0]  free_idx, wr_idx;
  logic              wr_data_en, wr_mask_en, wr_fill, wr_half;
  logic [BEAT_W-1:0] wr_beat;
  logic [WORD_W-1:0] wr_word;

  mbw_seq #(.ENTRIES(ENTRIES), .BEATS(BEATS)) u_seq (
    .clk, .rst_n, .hdr_vld, .rx_word,
    .full, .cur_slot(free_idx),
    .busy, .hdr_err, .op_done, .op_fin,
    .wr_data_en, .wr_mask_en, .wr_fill, .wr_half,
    .wr_beat, .wr_idx, .wr_word
  );

  mbw_pool #(.ENTRIES(ENTRIES)) u_pool (
    .clk, .rst_n,
    .alloc_vld(op_fin), .alloc_idx(wr_idx),
    .rel_vld, .rel_idx,
    .free_code, .free_idx, .full
  );

  mbw_store #(.ENTRIES(ENTRIES), .BEATS(BEATS)) u_store (
    .clk, .rst_n,
    .wr_data_en, .wr_mask_en, .wr_fill, .wr_half,
    .wr_beat, .wr_idx, .wr_word,
    .rd_idx, .rd_data, .rd_mask
  );

  assign wr_slot = busy ? SLOT_W'(wr_idx) : free_code;

  // R9
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && hdr_vld && (wr_slot == SLOT_W'(FULL_CODE)) |=> !busy && !hdr_err);
  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wr_slot));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !busy);
endmodule

// File: tb/mbw_receiver_test.sv
`timescale 1ns/1ps
module mbw_receiver_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         hdr_vld;
  logic [15:0]  rx_word;
  logic         rel_vld;
  logic [1:0]   rel_idx;
  logic [1:0]   rd_idx;
  logic [3:0]   wr_slot;
  logic         busy, op_done, hdr_err;
  logic [511:0] rd_data;
  logic [31:0]  rd_mask;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0]  exp_b [4][64];
  logic [15:0] exp_m [4][2];
  bit          occ   [4];

  always #2.5 clk = ~clk;

  mbw_receiver uut (
    .clk, .rst_n, .hdr_vld, .rx_word, .rel_vld, .rel_idx, .rd_idx,
    .wr_slot, .busy, .op_done, .hdr_err, .rd_data, .rd_mask
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_slot();
    for (int i = 0; i < 4; i++) if (!occ[i]) return 4'(i);
    return 4'd8;
  endfunction

  function automatic logic [15:0] beat_word(input int seed, input int part, input int k);
    return 16'(seed * 16'h1357 + part * 16'h0f0f + k * 16'h0111 + 16'h2468);
  endfunction

  task automatic chk_entry(input int s, input string req);
    logic [511:0] eb;
    for (int b = 0; b < 64; b++) eb[b*8 +: 8] = exp_b[s][b];
    rd_idx = 2'(s);
    #0.5;
    chk({req, " entry bytes"}, rd_data, eb);
    chk({req, " entry mask"}, rd_mask, {exp_m[s][1], exp_m[s][0]});
  endtask

  // one full write operation; err_beat >= 0 raises a stray header on that data beat
  task automatic send_op(input int slot, input bit masked, input bit wide, input bit upper,
                         input logic [12:0] rsvd, input logic [15:0] mlo, input logic [15:0] mhi,
                         input int seed, input int err_beat, input string req);
    int bad = 0;
    int nparts = wide ? 2 : 1;
    int total = nparts * (16 + (masked ? 1 : 0));
    int cnt = 0;
    @(negedge clk);
    hdr_vld = 1'b1;
    rx_word = {rsvd, upper, wide, masked};
    @(negedge clk);
    hdr_vld = 1'b0;
    chk({req, " R7 slot during op"}, wr_slot, 4'(slot));
    for (int p = 0; p < nparts; p++) begin
      int h = wide ? p : int'(upper);
      if (masked) begin
        rx_word = (p == 0) ? mlo : mhi;
        exp_m[slot][h] = rx_word;
        @(negedge clk);
        cnt++;
        if (cnt < total && (!busy || op_done)) bad++;
      end else begin
        exp_m[slot][h] = 16'hffff;
      end
      for (int k = 0; k < 16; k++) begin
        logic [15:0] w = beat_word(seed, p, k);
        rx_word = w;
        exp_b[slot][h*32 + 2*k]     = w[7:0];
        exp_b[slot][h*32 + 2*k + 1] = w[15:8];
        if (p * 16 + k == err_beat) hdr_vld = 1'b1;
        @(negedge clk);
        cnt++;
        if (p * 16 + k == err_beat) begin
          hdr_vld = 1'b0;
          chk({req, " R8 hdr_err after stray header"}, hdr_err, 1'b1);
        end
        if (cnt < total && (!busy || op_done)) bad++;
      end
    end
    occ[slot] = 1'b1;
    chk({req, " R6 busy held for every beat"}, bad, 0);
    chk({req, " R7 op_done pulse"}, op_done, 1'b1);
    chk({req, " R6 busy low after last beat"}, busy, 1'b0);
    chk({req, " R7 next free slot"}, wr_slot, model_slot());
    chk_entry(slot, {req, " R3"});
    @(negedge clk);
    chk({req, " R7 op_done single cycle"}, op_done, 1'b0);
    chk({req, " R8 no error without stray header"}, hdr_err, 1'b0);
  endtask

  task automatic release_entry(input int s, input string req);
    @(negedge clk);
    rel_vld = 1'b1;
    rel_idx = 2'(s);
    @(negedge clk);
    rel_vld = 1'b0;
    occ[s] = 1'b0;
    chk({req, " R10 slot after release"}, wr_slot, model_slot());
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) begin
      occ[s] = 1'b0;
      exp_m[s][0] = '0;
      exp_m[s][1] = '0;
      for (int b = 0; b < 64; b++) exp_b[s][b] = '0;
    end
    chk("R1 wr_slot", wr_slot, 4'd0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 op_done", op_done, 1'b0);
    chk("R1 hdr_err", hdr_err, 1'b0);
    chk_entry(0, "R1");
    chk_entry(3, "R1");
  endtask

  task automatic t_full_reject();
    @(negedge clk);
    chk("R9 full code", wr_slot, 4'd8);
    hdr_vld = 1'b1;
    rx_word = 16'h0003;
    @(negedge clk);
    hdr_vld = 1'b0;
    chk("R9 busy stays low", busy, 1'b0);
    chk("R9 no error", hdr_err, 1'b0);
    for (int k = 0; k < 4; k++) begin
      rx_word = 16'hdead;
      @(negedge clk);
    end
    chk("R9 still idle", busy, 1'b0);
    chk_entry(0, "R9 unchanged");
    chk_entry(3, "R9 unchanged");
  endtask

  initial begin
    rst_n = 1'b0;
    hdr_vld = 1'b0;
    rx_word = '0;
    rel_vld = 1'b0;
    rel_idx = '0;
    rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R5: narrow, lower half, no mask
    send_op(0, 1'b0, 1'b0, 1'b0, 13'h0000, 16'h0, 16'h0, 1, -1, "opA R5 R4");
    release_entry(0, "relA");
    // R2: reserved bits set; R5: upper half only, lower half kept
    send_op(0, 1'b1, 1'b0, 1'b1, 13'h1fff, 16'ha5c3, 16'h0, 2, -1, "opB R2 R5");
    // R6: wide with masks; R8: stray header on data beat 5
    send_op(1, 1'b1, 1'b1, 1'b1, 13'h0000, 16'h1234, 16'h8001, 3, 5, "opC R6 R8");
    // R6: wide without masks
    send_op(2, 1'b0, 1'b1, 1'b0, 13'h0a0a, 16'h0, 16'h0, 4, -1, "opD R6");
    // R4: narrow lower half with mask, fills the last entry
    send_op(3, 1'b1, 1'b0, 1'b0, 13'h0000, 16'h00f0, 16'h0, 5, -1, "opE R4");
    t_full_reject();
    release_entry(2, "relC");
    release_entry(0, "relD");
    // R10: lowest free chosen after two releases
    send_op(0, 1'b1, 1'b1, 1'b0, 13'h0000, 16'h0f0f, 16'hf0f0, 6, -1, "opF R10");
    chk_entry(1, "R8 stray header left data intact");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule